// File: doc/BRIEF.md
# Framebuffer Rectangle Fill and Copy Engine

This block draws into a linear framebuffer that lives in a byte-addressed synchronous memory. It performs two operations: a solid fill of a rectangle with a colour, and a copy of a rectangle from one place on the screen to another. The pixel size in bytes and the screen width in pixels are configuration inputs, so the same engine serves 8-, 16-, 24- and 32-bit pixel formats.

A command is presented with `cmd_valid` while `cmd_ready` is high. The engine then runs byte by byte through the memory port, raises `done` for one cycle and, in the same cycle, presents the destination rectangle as a dirty region so that a display path can refresh only that area. Copies whose source and destination rectangles overlap vertically produce the same result as an ideal move, because the row order is chosen from the relative positions of the two rectangles.

Top module: `rect_blit_engine`

## Requirements
- R1: `cmd_ready` is high exactly while the engine is idle; a command is taken only when `cmd_valid` and `cmd_ready` are both high, and a command presented while busy has no effect on memory or on the running operation. No memory access happens while idle.
- R2: The row pitch is `cfg_bpp * cfg_width` bytes, and the first byte of pixel (x, y) is at address `cfg_bpp * x + pitch * y`.
- R3: Every operation touches `cfg_bpp * w` bytes in each of `h` rows, and writes no other byte.
- R4: A copy (`cmd_op` = 1) whose destination y is greater than its source y processes rows from the last row (y + h - 1) upward, stepping one pitch back per row; otherwise it processes rows from the top downward.
- R5: A fill (`cmd_op` = 0) splits `cmd_colour` into bytes, least significant byte first, and emits pixel bytes by cycling through the first `cfg_bpp` of them, restarting at byte 0 at the start of the row.
- R6: A fill writes its first row from the colour pattern and builds every later row by reading the first row and writing it one pitch further down per row; all reads of a fill lie inside the first row.
- R7: At the end of every command `done` is high for exactly one cycle, and in that cycle `dirty_x`, `dirty_y`, `dirty_w`, `dirty_h` equal the command's `cmd_dx`, `cmd_dy`, `cmd_w`, `cmd_h`; the next cycle the engine is idle.
- R8: A command with `cmd_h` = 0 or `cmd_w` = 0 performs no memory access and still completes with a `done` pulse and its dirty record.
- R9: Within a row, bytes move in ascending address order, one byte at a time; a copied byte is read in one cycle and written in the next, using the one-cycle read latency of the memory, and a read and a write never share a cycle.
- R10: After reset the engine is idle with `cmd_ready` high, `done` low and both memory enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bpp | input | 3 | Bytes per pixel, 1 to 4, sampled when a command is taken |
| cfg_width | input | COORD_W | Screen width in pixels, sampled when a command is taken |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High while idle; command taken when both are high |
| cmd_op | input | 1 | 0 = fill, 1 = copy |
| cmd_colour | input | 32 | Fill colour, least significant byte first |
| cmd_sx | input | COORD_W | Copy source x (pixels) |
| cmd_sy | input | COORD_W | Copy source y (rows) |
| cmd_dx | input | COORD_W | Destination x (pixels) |
| cmd_dy | input | COORD_W | Destination y (rows) |
| cmd_w | input | COORD_W | Rectangle width in pixels |
| cmd_h | input | COORD_W | Rectangle height in rows |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write byte address |
| mem_wr_data | output | 8 | Memory write data |
| done | output | 1 | One-cycle completion pulse |
| dirty_x | output | COORD_W | Dirty region x, valid with `done` |
| dirty_y | output | COORD_W | Dirty region y, valid with `done` |
| dirty_w | output | COORD_W | Dirty region width, valid with `done` |
| dirty_h | output | COORD_W | Dirty region height, valid with `done` |

## Verification
The bench builds the engine with `ADDR_W` = 12 and `COORD_W` = 8 on a 16-pixel-wide screen, so a 4096-byte memory holds the whole framebuffer at every pixel size and the bench can compare the full memory image against its own model after each command. With those values every pixel size from 1 to 4 bytes is reachable, including the 3-byte case where the colour cycle does not divide a word, and rectangles can be placed so that copies overlap upward, downward and within a single row. Zero-height commands and commands issued while busy are driven through the same ports.

// File: rtl/rect_blit_pkg.sv
// Shared types for the rectangle fill/copy engine.
// Assumes: operation code is one bit; states are few enough for a 3-bit code.
package rect_blit_pkg;

    // Operation selected by cmd_op.
    typedef enum logic {
        OP_FILL = 1'b0,
        OP_COPY = 1'b1
    } blit_op_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // waiting for a command
        ST_PAT  = 3'd1,  // fill: writing first row from colour pattern
        ST_RD   = 3'd2,  // issuing one byte read
        ST_WR   = 3'd3,  // writing the byte read in the previous cycle
        ST_FIN  = 3'd4   // completion pulse
    } blit_state_e;

endpackage

// File: rtl/rect_blit_addr.sv
// Row address generator.
// Computes the pitch, the row length in bytes and the first source and
// destination row addresses when a command is loaded, then steps the row
// bases by one pitch per row. Copies with the destination below the source
// start at the last row and step backwards. For a fill the source base stays
// on the first destination row, so later rows replicate it.
// Assumes: ADDR_W wide enough for the whole framebuffer; h > 0 when rows run.
module rect_blit_addr
    import rect_blit_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int COORD_W = 10,
    parameter int RB_W    = COORD_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               adv_row,
    input  logic               op,
    input  logic [2:0]         bpp,
    input  logic [COORD_W-1:0] scr_w,
    input  logic [COORD_W-1:0] sx,
    input  logic [COORD_W-1:0] sy,
    input  logic [COORD_W-1:0] dx,
    input  logic [COORD_W-1:0] dy,
    input  logic [COORD_W-1:0] w,
    input  logic [COORD_W-1:0] h,
    output logic [ADDR_W-1:0]  src_base,
    output logic [ADDR_W-1:0]  dst_base,
    output logic [RB_W-1:0]    row_bytes,
    output logic [2:0]         bpp_q
);

    logic [ADDR_W-1:0] pitch_c;
    logic [ADDR_W-1:0] src_top_c;
    logic [ADDR_W-1:0] dst_top_c;
    logic [ADDR_W-1:0] last_off_c;
    logic              rev_c;
    logic [ADDR_W-1:0] pitch_q;
    logic              rev_q;
    logic              fill_q;

    // Start-of-rectangle arithmetic for the incoming command.
    always_comb begin
        pitch_c    = ADDR_W'(bpp) * ADDR_W'(scr_w);
        src_top_c  = ADDR_W'(bpp) * ADDR_W'(sx) + pitch_c * ADDR_W'(sy);
        dst_top_c  = ADDR_W'(bpp) * ADDR_W'(dx) + pitch_c * ADDR_W'(dy);
        last_off_c = pitch_c * (ADDR_W'(h) - ADDR_W'(1));
        rev_c      = (op == OP_COPY) && (dy > sy);
    end

    // Load row bases on command accept, step them once per finished row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_base  <= '0;
            dst_base  <= '0;
            pitch_q   <= '0;
            row_bytes <= '0;
            bpp_q     <= 3'd1;
            rev_q     <= 1'b0;
            fill_q    <= 1'b0;
        end else if (load) begin
            pitch_q   <= pitch_c;
            row_bytes <= RB_W'(bpp) * RB_W'(w);
            bpp_q     <= bpp;
            rev_q     <= rev_c;
            fill_q    <= (op == OP_FILL);
            if (op == OP_FILL) begin
                src_base <= dst_top_c;
                dst_base <= dst_top_c;
            end else if (rev_c) begin
                src_base <= src_top_c + last_off_c;
                dst_base <= dst_top_c + last_off_c;
            end else begin
                src_base <= src_top_c;
                dst_base <= dst_top_c;
            end
        end else if (adv_row) begin
            if (fill_q) begin
                dst_base <= dst_base + pitch_q;
            end else if (rev_q) begin
                src_base <= src_base - pitch_q;
                dst_base <= dst_base - pitch_q;
            end else begin
                src_base <= src_base + pitch_q;
                dst_base <= dst_base + pitch_q;
            end
        end
    end

endmodule

// File: rtl/rect_blit_pattern.sv
// Colour byte replicator.
// Selects the colour byte for the current pixel-byte phase (least
// significant byte first) and gives the phase that follows, wrapping after
// bpp bytes. Purely combinational.
// Assumes: bpp in 1..4, phase < bpp.
module rect_blit_pattern (
    input  logic [31:0] colour,
    input  logic [2:0]  bpp,
    input  logic [1:0]  phase,
    output logic [7:0]  pat_byte,
    output logic [1:0]  next_phase
);

    // Byte select and phase wrap.
    always_comb begin
        pat_byte = colour[8*phase +: 8];
        if ({1'b0, phase} >= bpp - 3'd1) next_phase = 2'd0;
        else                             next_phase = phase + 2'd1;
    end

endmodule

// File: rtl/rect_blit_ctrl.sv
// Operation sequencer.
// Accepts a command while idle, latches the colour, height and dirty record,
// then walks bytes and rows: a fill writes its first row from the pattern
// and copies it downward; a copy moves each byte with a read cycle followed
// by a write cycle. Ends with a one-cycle done pulse.
// Assumes: memory read data arrives one cycle after the read strobe;
// row_bytes and the row bases come from rect_blit_addr, loaded on accept.
module rect_blit_ctrl
    import rect_blit_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int RB_W    = COORD_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_op,
    input  logic [31:0]        cmd_colour,
    input  logic [COORD_W-1:0] cmd_dx,
    input  logic [COORD_W-1:0] cmd_dy,
    input  logic [COORD_W-1:0] cmd_w,
    input  logic [COORD_W-1:0] cmd_h,
    input  logic [RB_W-1:0]    row_bytes,
    input  logic [7:0]         pat_byte,
    input  logic [1:0]         next_phase,
    input  logic [7:0]         rd_data,
    output logic               cmd_ready,
    output logic               load,
    output logic               adv_row,
    output logic [RB_W-1:0]    byte_idx,
    output logic [1:0]         phase,
    output logic [31:0]        colour_q,
    output logic               rd_en,
    output logic               wr_en,
    output logic [7:0]         wr_data,
    output logic               done,
    output logic [COORD_W-1:0] dirty_x,
    output logic [COORD_W-1:0] dirty_y,
    output logic [COORD_W-1:0] dirty_w,
    output logic [COORD_W-1:0] dirty_h
);

    blit_state_e        state;
    logic [COORD_W-1:0] h_q;
    logic [COORD_W-1:0] row_idx;
    logic               last_byte;
    logic               last_row;

    // Row and byte end conditions.
    always_comb begin
        last_byte = (byte_idx == row_bytes - RB_W'(1));
        last_row  = (row_idx == h_q - COORD_W'(1));
    end

    // Strobes and data toward memory and the address generator.
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        load      = (state == ST_IDLE) && cmd_valid;
        rd_en     = (state == ST_RD);
        wr_en     = (state == ST_PAT) || (state == ST_WR);
        wr_data   = (state == ST_PAT) ? pat_byte : rd_data;
        done      = (state == ST_FIN);
        adv_row   = ((state == ST_PAT) && last_byte) ||
                    ((state == ST_WR) && last_byte && !last_row);
    end

    // Sequencer: command capture, byte and row counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            h_q      <= '0;
            row_idx  <= '0;
            byte_idx <= '0;
            phase    <= 2'd0;
            colour_q <= '0;
            dirty_x  <= '0;
            dirty_y  <= '0;
            dirty_w  <= '0;
            dirty_h  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        h_q      <= cmd_h;
                        colour_q <= cmd_colour;
                        dirty_x  <= cmd_dx;
                        dirty_y  <= cmd_dy;
                        dirty_w  <= cmd_w;
                        dirty_h  <= cmd_h;
                        row_idx  <= '0;
                        byte_idx <= '0;
                        phase    <= 2'd0;
                        if ((cmd_h == '0) || (cmd_w == '0)) state <= ST_FIN;
                        else if (cmd_op == OP_FILL)          state <= ST_PAT;
                        else                                 state <= ST_RD;
                    end
                end
                ST_PAT: begin
                    if (last_byte) begin
                        byte_idx <= '0;
                        row_idx  <= COORD_W'(1);
                        state    <= (h_q == COORD_W'(1)) ? ST_FIN : ST_RD;
                    end else begin
                        byte_idx <= byte_idx + RB_W'(1);
                        phase    <= next_phase;
                    end
                end
                ST_RD: begin
                    state <= ST_WR;
                end
                ST_WR: begin
                    if (last_byte) begin
                        byte_idx <= '0;
                        if (last_row) begin
                            state <= ST_FIN;
                        end else begin
                            row_idx <= row_idx + COORD_W'(1);
                            state   <= ST_RD;
                        end
                    end else begin
                        byte_idx <= byte_idx + RB_W'(1);
                        state    <= ST_RD;
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rect_blit_engine.sv
// Rectangle fill/copy engine top.
// Joins the sequencer, the row address generator and the colour byte
// replicator, and forms byte addresses as row base plus byte index.
// Assumes: synchronous byte memory with one-cycle read latency; cfg_bpp in
// 1..4; rectangles lie inside the framebuffer (no clipping here).
module rect_blit_engine
    import rect_blit_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int COORD_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cfg_bpp,
    input  logic [COORD_W-1:0] cfg_width,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_op,
    input  logic [31:0]        cmd_colour,
    input  logic [COORD_W-1:0] cmd_sx,
    input  logic [COORD_W-1:0] cmd_sy,
    input  logic [COORD_W-1:0] cmd_dx,
    input  logic [COORD_W-1:0] cmd_dy,
    input  logic [COORD_W-1:0] cmd_w,
    input  logic [COORD_W-1:0] cmd_h,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic [7:0]         mem_rd_data,
    output logic               mem_wr_en,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [7:0]         mem_wr_data,
    output logic               done,
    output logic [COORD_W-1:0] dirty_x,
    output logic [COORD_W-1:0] dirty_y,
    output logic [COORD_W-1:0] dirty_w,
    output logic [COORD_W-1:0] dirty_h
);

    localparam int RB_W = COORD_W + 3;

    logic              load;
    logic              adv_row;
    logic [ADDR_W-1:0] src_base;
    logic [ADDR_W-1:0] dst_base;
    logic [RB_W-1:0]   row_bytes;
    logic [2:0]        bpp_q;
    logic [RB_W-1:0]   byte_idx;
    logic [1:0]        phase;
    logic [1:0]        next_phase;
    logic [31:0]       colour_q;
    logic [7:0]        pat_byte;

    rect_blit_addr #(
        .ADDR_W  (ADDR_W),
        .COORD_W (COORD_W),
        .RB_W    (RB_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .adv_row   (adv_row),
        .op        (cmd_op),
        .bpp       (cfg_bpp),
        .scr_w     (cfg_width),
        .sx        (cmd_sx),
        .sy        (cmd_sy),
        .dx        (cmd_dx),
        .dy        (cmd_dy),
        .w         (cmd_w),
        .h         (cmd_h),
        .src_base  (src_base),
        .dst_base  (dst_base),
        .row_bytes (row_bytes),
        .bpp_q     (bpp_q)
    );

    rect_blit_pattern u_pat (
        .colour     (colour_q),
        .bpp        (bpp_q),
        .phase      (phase),
        .pat_byte   (pat_byte),
        .next_phase (next_phase)
    );

    rect_blit_ctrl #(
        .COORD_W (COORD_W),
        .RB_W    (RB_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_colour (cmd_colour),
        .cmd_dx     (cmd_dx),
        .cmd_dy     (cmd_dy),
        .cmd_w      (cmd_w),
        .cmd_h      (cmd_h),
        .row_bytes  (row_bytes),
        .pat_byte   (pat_byte),
        .next_phase (next_phase),
        .rd_data    (mem_rd_data),
        .cmd_ready  (cmd_ready),
        .load       (load),
        .adv_row    (adv_row),
        .byte_idx   (byte_idx),
        .phase      (phase),
        .colour_q   (colour_q),
        .rd_en      (mem_rd_en),
        .wr_en      (mem_wr_en),
        .wr_data    (mem_wr_data),
        .done       (done),
        .dirty_x    (dirty_x),
        .dirty_y    (dirty_y),
        .dirty_w    (dirty_w),
        .dirty_h    (dirty_h)
    );

    // Byte addresses: row base plus position in the row.
    always_comb begin
        mem_rd_addr = src_base + ADDR_W'(byte_idx);
        mem_wr_addr = dst_base + ADDR_W'(byte_idx);
    end

endmodule

// Port-level protocol checks for rect_blit_engine.
module rect_blit_engine_sva #(
    parameter int COORD_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_ready,
    input logic               mem_rd_en,
    input logic               mem_wr_en,
    input logic               done,
    input logic [COORD_W-1:0] dirty_x,
    input logic [COORD_W-1:0] dirty_y,
    input logic [COORD_W-1:0] dirty_w,
    input logic [COORD_W-1:0] dirty_h
);

    // R1: no memory traffic while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mem_rd_en && !mem_wr_en));

    // R7: done lasts one cycle and is followed by idle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));

    // R7: done never coincides with readiness
    assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_ready);

    // R7: dirty record holds while an operation runs
    assert_dirty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> ($stable(dirty_x) && $stable(dirty_y) &&
                        $stable(dirty_w) && $stable(dirty_h)));

    // R9: every read is followed by a write in the next cycle
    assert_rd_then_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en);

    // R9: read and write never share a cycle
    assert_rw_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

endmodule

bind rect_blit_engine rect_blit_engine_sva #(.COORD_W(COORD_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .done      (done),
    .dirty_x   (dirty_x),
    .dirty_y   (dirty_y),
    .dirty_w   (dirty_w),
    .dirty_h   (dirty_h)
);

// File: tb/rect_blit_engine_tb.sv
module rect_blit_engine_tb;

    localparam int PERIOD  = 10;
    localparam int ADDR_W  = 12;
    localparam int COORD_W = 8;
    localparam int MEM_N   = 1 << ADDR_W;
    localparam int SCR_W   = 16;
    localparam int NVEC    = 10;

    typedef struct packed {
        logic        op;
        logic [2:0]  bpp;
        logic [31:0] colour;
        logic [7:0]  sx;
        logic [7:0]  sy;
        logic [7:0]  dx;
        logic [7:0]  dy;
        logic [7:0]  w;
        logic [7:0]  h;
    } vec_t;

    // op, bpp, colour, sx, sy, dx, dy, w, h
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd1, 32'hA1B2C3D4, 8'd0, 8'd0,  8'd2,  8'd1, 8'd5, 8'd3},
        '{1'b0, 3'd2, 32'h11223344, 8'd0, 8'd0,  8'd3,  8'd4, 8'd4, 8'd2},
        '{1'b0, 3'd3, 32'h00CAFE77, 8'd0, 8'd0,  8'd1,  8'd6, 8'd3, 8'd3},
        '{1'b0, 3'd4, 32'h89ABCDEF, 8'd0, 8'd0,  8'd10, 8'd2, 8'd6, 8'd4},
        '{1'b1, 3'd2, 32'h0,        8'd0, 8'd0,  8'd8,  8'd10, 8'd5, 8'd4},
        '{1'b1, 3'd1, 32'h0,        8'd2, 8'd3,  8'd2,  8'd5, 8'd6, 8'd5},
        '{1'b1, 3'd4, 32'h0,        8'd4, 8'd8,  8'd4,  8'd5, 8'd4, 8'd6},
        '{1'b1, 3'd3, 32'h0,        8'd0, 8'd10, 8'd3,  8'd10, 8'd4, 8'd2},
        '{1'b0, 3'd2, 32'hDEADBEEF, 8'd0, 8'd0,  8'd5,  8'd5, 8'd3, 8'd0},
        '{1'b0, 3'd3, 32'h00135724, 8'd0, 8'd0,  8'd15, 8'd13, 8'd1, 8'd1}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2:0]         cfg_bpp = 3'd1;
    logic [COORD_W-1:0] cfg_width = COORD_W'(SCR_W);
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic               cmd_op = 1'b0;
    logic [31:0]        cmd_colour = '0;
    logic [COORD_W-1:0] cmd_sx = '0, cmd_sy = '0, cmd_dx = '0, cmd_dy = '0;
    logic [COORD_W-1:0] cmd_w = '0, cmd_h = '0;
    logic               mem_rd_en;
    logic [ADDR_W-1:0]  mem_rd_addr;
    logic [7:0]         mem_rd_data;
    logic               mem_wr_en;
    logic [ADDR_W-1:0]  mem_wr_addr;
    logic [7:0]         mem_wr_data;
    logic               done;
    logic [COORD_W-1:0] dirty_x, dirty_y, dirty_w, dirty_h;

    logic [7:0] mem   [MEM_N];
    logic [7:0] model [MEM_N];

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int rd_out = 0;
    bit fill_watch = 1'b0;
    int row0_lo = 0;
    int row0_hi = 0;

    always #(PERIOD/2) clk = ~clk;

    rect_blit_engine #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_bpp(cfg_bpp), .cfg_width(cfg_width),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_colour(cmd_colour), .cmd_sx(cmd_sx), .cmd_sy(cmd_sy),
        .cmd_dx(cmd_dx), .cmd_dy(cmd_dy), .cmd_w(cmd_w), .cmd_h(cmd_h),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .done(done), .dirty_x(dirty_x), .dirty_y(dirty_y),
        .dirty_w(dirty_w), .dirty_h(dirty_h)
    );

    // Synchronous byte memory with one-cycle read latency, plus traffic monitor.
    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_rd_en) begin
            rd_cnt <= rd_cnt + 1;
            if (fill_watch && (int'(mem_rd_addr) < row0_lo || int'(mem_rd_addr) >= row0_hi))
                rd_out <= rd_out + 1;
        end
        mem_rd_data <= mem[mem_rd_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference fill: pattern row then rows copied from row 0, ascending bytes.
    task automatic model_fill(input vec_t v);
        int pitch = int'(v.bpp) * SCR_W;
        int base  = int'(v.bpp) * int'(v.dx) + pitch * int'(v.dy);
        int rb    = int'(v.bpp) * int'(v.w);
        if (v.h == 0 || v.w == 0) return;
        for (int k = 0; k < rb; k++) model[base + k] = v.colour[8*(k % int'(v.bpp)) +: 8];
        for (int r = 1; r < int'(v.h); r++)
            for (int k = 0; k < rb; k++) model[base + r*pitch + k] = model[base + k];
    endtask

    // Reference copy: row order by relative y, ascending bytes within a row.
    task automatic model_copy(input vec_t v);
        int pitch = int'(v.bpp) * SCR_W;
        int sb    = int'(v.bpp) * int'(v.sx) + pitch * int'(v.sy);
        int db    = int'(v.bpp) * int'(v.dx) + pitch * int'(v.dy);
        int rb    = int'(v.bpp) * int'(v.w);
        int r;
        if (v.h == 0 || v.w == 0) return;
        for (int n = 0; n < int'(v.h); n++) begin
            r = (v.dy > v.sy) ? (int'(v.h) - 1 - n) : n;
            for (int k = 0; k < rb; k++) model[db + r*pitch + k] = model[sb + r*pitch + k];
        end
    endtask

    task automatic compare_mem(input string req);
        int first = -1;
        for (int i = 0; i < MEM_N; i++)
            if (mem[i] !== model[i] && first < 0) first = i;
        if (first < 0) check(1'b1, req, "memory image", 0, 0);
        else check(1'b0, req, $sformatf("memory byte %0d", first), mem[first], model[first]);
    endtask

    task automatic drive_cmd(input vec_t v);
        cfg_bpp = v.bpp;  cmd_op = v.op; cmd_colour = v.colour;
        cmd_sx = v.sx; cmd_sy = v.sy; cmd_dx = v.dx; cmd_dy = v.dy;
        cmd_w = v.w; cmd_h = v.h;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < 5000 && !seen; c++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    // Issue one vector and check memory, dirty record, traffic and done pulse.
    task automatic run_vec(input vec_t v, input int idx);
        bit seen;
        int rb = int'(v.bpp) * int'(v.w);
        int nbytes = (v.h == 0 || v.w == 0) ? 0 : rb * int'(v.h);
        int nreads = (v.h == 0 || v.w == 0) ? 0 : (v.op ? nbytes : rb * (int'(v.h) - 1));
        @(negedge clk);
        wr_cnt = 0; rd_cnt = 0; rd_out = 0;
        fill_watch = !v.op;
        row0_lo = int'(v.bpp) * int'(v.dx) + int'(v.bpp) * SCR_W * int'(v.dy);
        row0_hi = row0_lo + rb;
        drive_cmd(v);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R1", $sformatf("vec %0d busy after accept", idx), cmd_ready, 0);
        wait_done(seen);
        check(seen, "R7", $sformatf("vec %0d done seen", idx), seen, 1);
        check({dirty_x, dirty_y, dirty_w, dirty_h} == {v.dx, v.dy, v.w, v.h}, "R7",
              $sformatf("vec %0d dirty record", idx),
              {dirty_x, dirty_y, dirty_w, dirty_h}, {v.dx, v.dy, v.w, v.h});
        @(negedge clk);
        check(done == 1'b0 && cmd_ready == 1'b1, "R7", $sformatf("vec %0d single done", idx),
              {done, cmd_ready}, 2'b01);
        if (v.op) model_copy(v); else model_fill(v);
        compare_mem(v.op ? "R4" : "R5");
        check(wr_cnt == nbytes, (v.h == 0) ? "R8" : "R3", $sformatf("vec %0d write count", idx),
              wr_cnt, nbytes);
        check(rd_cnt == nreads, v.op ? "R9" : "R6", $sformatf("vec %0d read count", idx),
              rd_cnt, nreads);
        if (!v.op)
            check(rd_out == 0, "R6", $sformatf("vec %0d fill reads outside row 0", idx), rd_out, 0);
        fill_watch = 1'b0;
    endtask

    initial begin
        vec_t busy_v;
        vec_t other_v;
        bit seen;
        for (int i = 0; i < MEM_N; i++) begin
            mem[i]   = 8'((i * 7 + 3) ^ (i >> 5));
            model[i] = 8'((i * 7 + 3) ^ (i >> 5));
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check(cmd_ready == 1'b1, "R10", "ready in reset", cmd_ready, 1);
        check(done == 1'b0 && mem_rd_en == 1'b0 && mem_wr_en == 1'b0, "R10",
              "quiet in reset", {done, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1 && done == 1'b0, "R10", "idle after reset",
              {cmd_ready, done}, 2'b10);

        // Main table: fills at each pixel size (R2, R5, R6), copies (R4, R9),
        // zero height (R8), single pixel at far corner (R2, R3).
        for (int n = 0; n < NVEC; n++) run_vec(VECS[n], n);

        // R1: command presented while busy has no effect
        busy_v  = '{1'b1, 3'd2, 32'h0, 8'd0, 8'd0, 8'd0, 8'd14, 8'd3, 8'd2};
        other_v = '{1'b0, 3'd4, 32'hFFFFFFFF, 8'd0, 8'd0, 8'd0, 8'd0, 8'd8, 8'd8};
        @(negedge clk);
        wr_cnt = 0;
        drive_cmd(busy_v);
        cmd_valid = 1'b1;
        @(negedge clk);
        drive_cmd(other_v);
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(seen);
        check(seen && dirty_y == 8'd14 && dirty_w == 8'd3, "R1", "busy command ignored, dirty",
              {dirty_y, dirty_w}, {8'd14, 8'd3});
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1", "idle after busy test", cmd_ready, 1);
        model_copy(busy_v);
        compare_mem("R1");
        check(wr_cnt == 12, "R1", "busy test write count", wr_cnt, 12);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule